// File: doc/BRIEF.md
# Nested Interrupt Context Sequencer

This block sits beside a small processor core and performs the context switch whenever an interrupt is taken or a handler finishes. The core has one task state and four executive classes, numbered 1 to 4, with 4 the most urgent. The core raises `instr_done` when an instruction has retired and presents the already advanced program counter on `pc_in`. Only at that boundary does the block look at `irq_req` and `ret_req`.

When a request is taken, the block goes busy and raises `lockout`. It writes the interrupted program counter and status word into a save block that belongs to the class being entered. It then reads that class's handler address and handler status word from a vector block. The status word holds the active class code and an enable mask, and both take effect as soon as the word is latched. A return request reloads the context from the save block of the class being left. This steps the core down exactly one nesting level. A small stack of open classes records the nesting and decides which save block to use on each return.

Memory is a single word-addressed port with one cycle of read latency. Class k (k = 1..4) uses save words `SAVE_BASE + 2(k-1)` (program counter) and `+1` (status word). It uses vector words `VEC_BASE + 2(k-1)` (handler address) and `+1` (handler status word).

Top module: `irq_ctx_sequencer`

## Requirements
- R1: While reset is held and until the first accepted event, `pc_out` is 0, `status_out` is `RST_SR` (0x00F0), `active_state` is 0, and `lockout`, `ret_err`, `mem_we` and `mem_re` are low.
- R2: Without `instr_done`, requests and returns are not acted on: no memory access occurs, and `pc_out` and `status_out` hold.
- R3: An accepted interrupt of class k causes, in four consecutive cycles starting the cycle after the boundary: a write of `pc_in` to `SAVE_BASE+2(k-1)`, a write of the old status word to `SAVE_BASE+2(k-1)+1`, a read of `VEC_BASE+2(k-1)`, and a read of `VEC_BASE+2(k-1)+1`. `lockout` is high from the first of these cycles up to and including the cycle in which the new status word is latched. Any boundary or request during that time is ignored.
- R4: After entry, `pc_out` equals the handler address word and `status_out` equals the handler status word. `active_state` equals status bits [2:0]. `lockout` is low from the next cycle on.
- R5: Among the eligible pending classes, the highest-numbered one is accepted.
- R6: A class is eligible only if its enable bit (status bit 3+k for class k) is set and k is above the class currently open. A boundary with no eligible request loads `pc_in` into `pc_out` and makes no memory access.
- R7: At a boundary with no return and no accepted request, `pc_out` takes `pc_in` in the next cycle.
- R8: An accepted return from class k reads `SAVE_BASE+2(k-1)` and then `+1` in the two cycles after the boundary. The next two cycles show the restored program counter and then the restored status word.
- R9: Returns unwind one nesting level each, and up to four classes nest. The task state is reached only after the last open handler returns.
- R10: A return at a boundary while in the task state raises `ret_err` in that same cycle. It makes no memory access and leaves `pc_out` and `status_out` unchanged.
- R11: When `ret_req` and an eligible interrupt arrive at the same boundary, the return is performed and the interrupt is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction boundary strobe |
| ret_req | input | 1 | Handler return request, valid with `instr_done` |
| irq_req | input | 4 | Pending requests, bit k-1 for class k |
| pc_in | input | DW | Program counter of the next instruction |
| mem_rdata | input | DW | Read data, one cycle after `mem_re` |
| mem_addr | output | AW | Word address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | DW | Write data |
| pc_out | output | DW | Current program counter |
| status_out | output | DW | Current status word |
| active_state | output | 3 | Active state code, 0 = task, 1..4 = class |
| lockout | output | 1 | Sequencer busy, no requests accepted |
| ret_err | output | 1 | Return attempted while in the task state |

## Verification
The hardest condition to reach is the full four-deep nesting, where each handler status word must enable the next class before the stack can fill. The stimulus climbs there one class at a time. At each boundary it raises only the next class up, then unwinds with four returns and checks the restored program counter and class at every level. Collisions are also produced on purpose: a boundary carrying both a return and a top-priority request, and a boundary that arrives during the locked entry sequence.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int NCLS      = 4;
  localparam int ST_W      = 3;
  localparam int SR_ST_LSB = 0;
  localparam int SR_EN_LSB = 4;

  typedef logic [ST_W-1:0] act_t;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_SAVE_PC,
    SQ_SAVE_SR,
    SQ_VEC_PC,
    SQ_VEC_SR,
    SQ_VEC_FIN,
    SQ_RET_PC,
    SQ_RET_SR,
    SQ_RET_FIN
  } seq_e;
endpackage

// File: rtl/isq_prio_pick.sv
module isq_prio_pick
  import isq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] req,
  input  logic [NCLS-1:0] en,
  input  act_t            act,
  output logic            any,
  output act_t            win
);
  logic [NCLS-1:0] elig;
  logic [NCLS-1:0] higher;
  logic [NCLS-1:0] grant;

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    assign elig[k] = req[k] & en[k] & (ST_W'(k + 1) > act);
    if (k == NCLS - 1) begin : g_top
      assign higher[k] = 1'b0;
    end else begin : g_low
      assign higher[k] = |elig[NCLS-1:k+1];
    end
    assign grant[k] = elig[k] & ~higher[k];
  end

  always_comb begin
    win = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (grant[k]) win = win | ST_W'(k + 1);
    end
  end

  assign any = |grant;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(req & en)) == '0); // R6
endmodule

// File: rtl/isq_nest_stack.sv
module isq_nest_stack
  import isq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  act_t push_val,
  output act_t top,
  output logic empty
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic [DEPTH-1:0][ST_W-1:0] ent;

  // Entry 0 is the task state and never changes.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_base
      assign ent[i] = '0;
    end else begin : g_slot
      act_t slot_q;
      logic slot_en;
      assign slot_en = push && (ptr_q == PW'(i - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q <= '0;
        else if (slot_en) slot_q <= push_val;
      end
      assign ent[i] = slot_q;
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (push) begin
      ptr_d  = ptr_q + 1'b1;
      ptr_en = 1'b1;
    end else if (pop) begin
      ptr_d  = ptr_q - 1'b1;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign top   = ent[ptr_q];
  assign empty = (ptr_q == '0);

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (ptr_q < PW'(DEPTH - 1))); // R9
  AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (ptr_q != '0)); // R10
  AST_STACK_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R9
endmodule

// File: rtl/isq_seq_ctrl.sv
module isq_seq_ctrl
  import isq_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          DW        = 16,
  parameter int          SAVE_BASE = 'h100,
  parameter int          VEC_BASE  = 'h040,
  parameter logic [15:0] RST_SR    = 16'h00F0,
  localparam int         BW        = $clog2(NCLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          ret_req,
  input  logic [DW-1:0] pc_in,
  input  logic          irq_any,
  input  act_t          irq_cls,
  input  act_t          stack_top,
  input  logic          stack_empty,
  input  logic [DW-1:0] mem_rdata,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] sr_q,
  output logic          lockout,
  output logic          ret_err
);
  seq_e          st_q, st_d;
  logic [BW-1:0] blk_q, blk_d;
  logic          blk_en;
  logic [DW-1:0] pc_d, sr_d;
  logic          pc_en, sr_en;
  logic [AW-1:0] sv_addr, vec_addr;

  assign sv_addr  = AW'(SAVE_BASE) + AW'({blk_q, 1'b0});
  assign vec_addr = AW'(VEC_BASE)  + AW'({blk_q, 1'b0});

  always_comb begin
    st_d      = st_q;
    blk_d     = blk_q;
    blk_en    = 1'b0;
    pc_d      = pc_q;
    pc_en     = 1'b0;
    sr_d      = sr_q;
    sr_en     = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    ret_err   = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      SQ_IDLE: begin
        if (instr_done) begin
          if (ret_req) begin
            if (stack_empty) begin
              ret_err = 1'b1;
            end else begin
              blk_d  = BW'(stack_top - 1'b1);
              blk_en = 1'b1;
              st_d   = SQ_RET_PC;
            end
          end else begin
            pc_d  = pc_in;
            pc_en = 1'b1;
            if (irq_any) begin
              blk_d  = BW'(irq_cls - 1'b1);
              blk_en = 1'b1;
              push   = 1'b1;
              st_d   = SQ_SAVE_PC;
            end
          end
        end
      end
      SQ_SAVE_PC: begin
        mem_we    = 1'b1;
        mem_addr  = sv_addr;
        mem_wdata = pc_q;
        st_d      = SQ_SAVE_SR;
      end
      SQ_SAVE_SR: begin
        mem_we    = 1'b1;
        mem_addr  = sv_addr | AW'(1);
        mem_wdata = sr_q;
        st_d      = SQ_VEC_PC;
      end
      SQ_VEC_PC: begin
        mem_re   = 1'b1;
        mem_addr = vec_addr;
        st_d     = SQ_VEC_SR;
      end
      SQ_VEC_SR: begin
        mem_re   = 1'b1;
        mem_addr = vec_addr | AW'(1);
        pc_d     = mem_rdata;
        pc_en    = 1'b1;
        st_d     = SQ_VEC_FIN;
      end
      SQ_VEC_FIN: begin
        sr_d  = mem_rdata;
        sr_en = 1'b1;
        st_d  = SQ_IDLE;
      end
      SQ_RET_PC: begin
        mem_re   = 1'b1;
        mem_addr = sv_addr;
        st_d     = SQ_RET_SR;
      end
      SQ_RET_SR: begin
        mem_re   = 1'b1;
        mem_addr = sv_addr | AW'(1);
        pc_d     = mem_rdata;
        pc_en    = 1'b1;
        st_d     = SQ_RET_FIN;
      end
      SQ_RET_FIN: begin
        sr_d  = mem_rdata;
        sr_en = 1'b1;
        pop   = 1'b1;
        st_d  = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      blk_q <= '0;
      pc_q  <= '0;
      sr_q  <= DW'(RST_SR);
    end else begin
      st_q <= st_d;
      if (blk_en) blk_q <= blk_d;
      if (pc_en)  pc_q  <= pc_d;
      if (sr_en)  sr_q  <= sr_d;
    end
  end

  assign lockout = (st_q != SQ_IDLE);

  AST_OFF_BOUNDARY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !instr_done) |=> (!lockout && $stable(pc_q) && $stable(sr_q))); // R2
  AST_ENTRY_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && instr_done && !ret_req && irq_any) |=> (mem_we && mem_wdata == $past(pc_in))); // R3
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> (!mem_we && !mem_re && $stable(sr_q))); // R10
  AST_RETURN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && instr_done && ret_req && !stack_empty) |=> (mem_re && !mem_we)); // R11
  AST_RETURN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (lockout && !push)); // R8
endmodule

// File: rtl/irq_ctx_sequencer.sv
module irq_ctx_sequencer
  import isq_pkg::*;
#(
  parameter int          AW         = 12,
  parameter int          DW         = 16,
  parameter int          SAVE_BASE  = 'h100,
  parameter int          VEC_BASE   = 'h040,
  parameter int          NEST_DEPTH = 5,
  parameter logic [15:0] RST_SR     = 16'h00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_done,
  input  logic            ret_req,
  input  logic [NCLS-1:0] irq_req,
  input  logic [DW-1:0]   pc_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   pc_out,
  output logic [DW-1:0]   status_out,
  output logic [ST_W-1:0] active_state,
  output logic            lockout,
  output logic            ret_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic  irq_any;
  act_t  irq_cls;
  act_t  stack_top;
  logic  stack_empty;
  logic  push, pop;
  logic [DW-1:0] sr_q;

  isq_prio_pick u_pick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (irq_req),
    .en    (sr_q[SR_EN_LSB +: NCLS]),
    .act   (stack_top),
    .any   (irq_any),
    .win   (irq_cls)
  );

  isq_nest_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push     (push),
    .pop      (pop),
    .push_val (irq_cls),
    .top      (stack_top),
    .empty    (stack_empty)
  );

  isq_seq_ctrl #(
    .AW        (AW),
    .DW        (DW),
    .SAVE_BASE (SAVE_BASE),
    .VEC_BASE  (VEC_BASE),
    .RST_SR    (RST_SR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .instr_done  (instr_done),
    .ret_req     (ret_req),
    .pc_in       (pc_in),
    .irq_any     (irq_any),
    .irq_cls     (irq_cls),
    .stack_top   (stack_top),
    .stack_empty (stack_empty),
    .mem_rdata   (mem_rdata),
    .push        (push),
    .pop         (pop),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_wdata   (mem_wdata),
    .pc_q        (pc_out),
    .sr_q        (sr_q),
    .lockout     (lockout),
    .ret_err     (ret_err)
  );

  assign status_out   = sr_q;
  assign active_state = sr_q[SR_ST_LSB +: ST_W];

  AST_LOCK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(lockout) |-> $past(instr_done)); // R2
  AST_ERR_ONLY_IN_TASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    ret_err |-> (stack_empty && !lockout)); // R10
endmodule

// File: tb/tb_irq_ctx_sequencer.sv
module tb_irq_ctx_sequencer;
  localparam int AW = 12, DW = 16, SAVE_B = 'h100, VEC_B = 'h040;

  logic clk = 1'b0;
  logic rst_n;
  logic instr_done, ret_req;
  logic [3:0] irq_req;
  logic [DW-1:0] pc_in, mem_rdata, mem_wdata, pc_out, status_out;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re, lockout, ret_err;
  logic [2:0] active_state;

  always #10 clk = ~clk;

  irq_ctx_sequencer dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ret_req(ret_req),
    .irq_req(irq_req), .pc_in(pc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .pc_out(pc_out),
    .status_out(status_out), .active_state(active_state), .lockout(lockout),
    .ret_err(ret_err)
  );

  function automatic logic [15:0] vec_pc(int k);
    return 16'(16'h0400 + k * 16'h0100);
  endfunction
  function automatic logic [15:0] vec_sr(int k);
    return {8'(8'hA0 + k), 4'(15 << k), 1'b0, 3'(k)};
  endfunction
  function automatic logic [15:0] init_word(int a);
    if (a >= VEC_B && a < VEC_B + 8)
      return ((a - VEC_B) % 2 == 0) ? vec_pc((a - VEC_B) / 2 + 1) : vec_sr((a - VEC_B) / 2 + 1);
    return 16'h0000;
  endfunction

  logic [15:0] mem [512];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else begin
      if (mem_re) mem_rdata <= mem[mem_addr[8:0]];
      if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    end
  end

  // Behavioural reference model
  typedef struct {bit we; bit re; int addr; int wdata; int ld; int ldaddr;} op_t;
  op_t q[$];
  int stk[$];
  logic [15:0] m_pc, m_sr;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  task automatic chk(string t, string what, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, got, exp);
    end
  endtask

  task automatic step(bit d, bit r, logic [3:0] irq, logic [15:0] pcin);
    op_t h;
    bit busy, eerr;
    int act, win, b;
    @(negedge clk);
    instr_done = d; ret_req = r; irq_req = irq; pc_in = pcin;
    #1;
    busy = (q.size() != 0);
    eerr = !busy && d && r && (stk.size() == 0);
    chk(tag, "lockout", int'(lockout), int'(busy));
    chk(tag, "pc_out", int'(pc_out), int'(m_pc));
    chk(tag, "status_out", int'(status_out), int'(m_sr));
    chk(tag, "active_state", int'(active_state), int'(m_sr[2:0]));
    chk(tag, "ret_err", int'(ret_err), int'(eerr));
    if (busy) begin
      h = q[0];
      chk(tag, "mem_we", int'(mem_we), int'(h.we));
      chk(tag, "mem_re", int'(mem_re), int'(h.re));
      if (h.we || h.re) chk(tag, "mem_addr", int'(mem_addr), h.addr);
      if (h.we) chk(tag, "mem_wdata", int'(mem_wdata), h.wdata);
    end else begin
      chk(tag, "mem_we", int'(mem_we), 0);
      chk(tag, "mem_re", int'(mem_re), 0);
    end
    if (busy) begin
      h = q.pop_front();
      if (h.ld == 1) m_pc = mem[h.ldaddr];
      else if (h.ld == 2) m_sr = mem[h.ldaddr];
    end else if (d) begin
      if (r) begin
        if (stk.size() > 0) begin
          b = 2 * (stk.pop_back() - 1);
          q.push_back('{0, 1, SAVE_B + b, 0, 0, 0});
          q.push_back('{0, 1, SAVE_B + b + 1, 0, 1, SAVE_B + b});
          q.push_back('{0, 0, 0, 0, 2, SAVE_B + b + 1});
        end
      end else begin
        act = (stk.size() > 0) ? stk[$] : 0;
        win = 0;
        for (int k = 4; k >= 1; k--)
          if (win == 0 && irq[k-1] && m_sr[3+k] && k > act) win = k;
        m_pc = pcin;
        if (win != 0) begin
          stk.push_back(win);
          b = 2 * (win - 1);
          q.push_back('{1, 0, SAVE_B + b, int'(m_pc), 0, 0});
          q.push_back('{1, 0, SAVE_B + b + 1, int'(m_sr), 0, 0});
          q.push_back('{0, 1, VEC_B + b, 0, 0, 0});
          q.push_back('{0, 1, VEC_B + b + 1, 0, 1, VEC_B + b});
          q.push_back('{0, 0, 0, 0, 2, VEC_B + b + 1});
        end
      end
    end
  endtask

  task automatic drain();
    while (q.size() != 0) step(0, 0, 4'h0, 16'h0);
  endtask

  task automatic at_rest(string t, int exp_act, int exp_pc);
    @(negedge clk); #1;
    chk(t, "active_state", int'(active_state), exp_act);
    chk(t, "pc_out", int'(pc_out), exp_pc);
  endtask

  initial begin
    rst_n = 1'b0; instr_done = 0; ret_req = 0; irq_req = '0; pc_in = '0;
    m_pc = 16'h0000; m_sr = 16'h00F0;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "pc_out", int'(pc_out), 0);
    chk("R1", "status_out", int'(status_out), 'h00F0);
    chk("R1", "lockout", int'(lockout), 0);
    chk("R1", "mem_we|mem_re", int'(mem_we | mem_re), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 4'h0, 16'h0);

    tag = "R2";   // requests without a boundary
    repeat (3) step(0, 0, 4'hF, 16'h0099);
    step(0, 1, 4'h0, 16'h0098);

    tag = "R7";
    step(1, 0, 4'h0, 16'h0011);
    step(1, 0, 4'h0, 16'h0012);

    tag = "R3";   // entry to class 2, boundaries during lockout ignored
    step(1, 0, 4'b0010, 16'h0013);
    repeat (3) step(1, 0, 4'b1000, 16'h0777);
    drain();
    at_rest("R4", 2, 'h0600);

    tag = "R6";   // class 1 and 2 masked inside class 2
    step(1, 0, 4'b0011, 16'h0601);

    tag = "R5";   // 3 and 4 together, 4 wins
    step(1, 0, 4'b1100, 16'h0602);
    drain();
    at_rest("R5", 4, 'h0800);

    tag = "R6";   // everything masked in class 4
    step(1, 0, 4'b1111, 16'h0801);

    tag = "R8";
    step(1, 1, 4'h0, 16'h0);
    drain();
    at_rest("R8", 2, 'h0602);

    tag = "R9";
    step(1, 1, 4'h0, 16'h0);
    drain();
    at_rest("R9", 0, 'h0013);

    tag = "R10";  // return in task state
    step(1, 1, 4'h0, 16'h0020);
    step(0, 0, 4'h0, 16'h0);
    at_rest("R10", 0, 'h0013);

    tag = "R11";  // return beats class 4 at the same boundary
    step(1, 0, 4'b0001, 16'h0030);
    drain();
    step(1, 1, 4'b1000, 16'h0531);
    drain();
    at_rest("R11", 0, 'h0030);

    tag = "R9";   // four-deep nesting and unwinding
    step(1, 0, 4'b0001, 16'h0040); drain();
    step(1, 0, 4'b0010, 16'h0541); drain();
    step(1, 0, 4'b0100, 16'h0642); drain();
    step(1, 0, 4'b1000, 16'h0743); drain();
    at_rest("R9", 4, 'h0800);
    step(1, 1, 4'h0, 16'h0); drain(); at_rest("R9", 3, 'h0743);
    step(1, 1, 4'h0, 16'h0); drain(); at_rest("R9", 2, 'h0642);
    step(1, 1, 4'h0, 16'h0); drain(); at_rest("R9", 1, 'h0541);
    step(1, 1, 4'h0, 16'h0); drain(); at_rest("R9", 0, 'h0040);
    chk("R9", "status_out", int'(status_out), 'h00F0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule